// File: doc/BRIEF.md
# Low-Power Stop Clock Controller

This block decides which clocks of a small microcontroller-style system keep running when the processor asks to enter a low-power stop. A one-cycle entry strobe carries the processor's current 3-bit interrupt mask. The block stores that mask and drops the system clock enable and every per-module clock enable. Whether the control clock and the external clock output keep running is set by two configuration bits, sampled on entry. The block then watches three wake sources: trace, reset, and prioritised interrupt requests. Only a request whose level is strictly above the stored mask ends the stop. Level 7 always ends it.

An optional third configuration bit switches the PLL off for the duration of the stop. When it is set, the block waits a fixed relock count after the wake event before it turns the system clock back on. All clock enables are retimed on the falling clock edge, so they only change while the clock is low. A downstream AND-type gate therefore never produces a runt pulse, and every clock that is off is held low.

The block also generates a bus clock at the system rate divided by 8 or by 16, with 50 % duty. It is driven only when a 2-bit pin-assignment field selects it. The divider restarts from phase zero whenever the divide selection changes or the block leaves stop.

Top module: `lpstop_clk_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge the block returns to run mode. After the release the system, control, external and per-module clock enables are on (module enables subject to their stop bits), `stop_active` is 0 and `pll_on` is 1.
- R2: A `stop_req` pulse sampled in run mode captures `stop_mask` and the three configuration bits, and the block enters stop. A `stop_req` sampled while stopped is ignored and leaves the stored mask unchanged.
- R3: While stopped, an `irq_level` sampled at a rising edge ends the stop only if it is greater than the stored mask, or equal to 7. Level 0 never wakes the block.
- R4: A `trace_req` sampled while stopped always ends the stop, whatever the stored mask and `irq_level`.
- R5: In stop and relock `sys_clk_en` and every `mod_clk_en` bit are 0. In run mode `mod_clk_en[i]` equals the inverse of `mod_stop[i]`.
- R6: In stop, `ctrl_clk_en` equals the keep-control bit and `ext_clk_en` equals the keep-external bit, both captured at entry. In run mode both are 1. During relock `ctrl_clk_en` is 1 and `ext_clk_en` is 0.
- R7: All clock-enable outputs change only on the falling edge of `clk`. A mode change at a rising edge becomes visible half a cycle later.
- R8: If the PLL-off bit was captured as 1, `pll_on` is 0 throughout the stop. After a wake the block spends exactly `RELOCK_CYC` cycles in relock with `pll_on` at 1 and the system clock off, then returns to run.
- R9: `bus_clk` has a period of 8 cycles when `bus_div16` is 0 and 16 cycles when it is 1. After a restart it is low for the first half of each period and high for the second half.
- R10: `bus_clk` toggles only in run mode when `bus_pin_mode` equals 2'b10. Otherwise it is held at 0, including throughout stop and relock.
- R11: The divider restarts from phase zero at the rising edge where a change of `bus_div16` is sampled, and at the edge where the block returns to run. The `bus_clk` value after the j-th following edge (j >= 1) is the half-period bit of j-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| stop_req | input | 1 | One-cycle stop-entry strobe |
| stop_mask | input | 3 | Interrupt mask carried with the entry strobe |
| trace_req | input | 1 | Trace exception request |
| irq_level | input | 3 | Highest pending interrupt level, 0 = none |
| cfg_keep_ctrl | input | 1 | Keep control clock running in stop |
| cfg_keep_ext | input | 1 | Keep external clock output running in stop |
| cfg_pll_off | input | 1 | Switch PLL off during stop |
| mod_stop | input | N_MOD | Per-module stop bits |
| bus_div16 | input | 1 | Bus clock divide select: 0 = /8, 1 = /16 |
| bus_pin_mode | input | 2 | Bus clock pin assignment, 2'b10 = driven |
| sys_clk_en | output | 1 | System clock gate enable |
| ctrl_clk_en | output | 1 | Control clock gate enable |
| ext_clk_en | output | 1 | External clock output gate enable |
| mod_clk_en | output | N_MOD | Per-module clock gate enables |
| pll_on | output | 1 | PLL power request |
| stop_active | output | 1 | High in stop and relock: pads hold, bus control negated |
| bus_clk | output | 1 | Divided bus clock |

## Verification
A wrong stored mask or a wrong comparison shows up in the first cycle after an interrupt is presented: `stop_active` stays high when it should fall, or falls when it should stay. The bench sweeps all 64 mask/level pairs to expose this. A relock counter that is off by one moves the rise of `sys_clk_en` by one cycle. A divider phase error shifts `bus_clk` within the first period after a restart. An enable stage registered on the wrong edge shows half a cycle early, when sampled between the rising and falling edges.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_RELOCK = 2'd2
  } lp_state_e;

  localparam logic [1:0] BUS_PIN_ON = 2'b10;
  localparam int         LVL_W      = 3;
  localparam logic [LVL_W-1:0] LVL_NMI = 3'd7;

  // Interrupt wake test: strictly above the stored mask, or the top level.
  function automatic logic irq_wakes(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] msk);
    return (lvl > msk) || (lvl == LVL_NMI);
  endfunction

endpackage

// File: rtl/lpstop_fsm.sv
`timescale 1ns/1ps
module lpstop_fsm
  import lpstop_pkg::*;
#(
  parameter int RELOCK_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic [LVL_W-1:0] stop_mask,
  input  logic             trace_req,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             cfg_keep_ctrl,
  input  logic             cfg_keep_ext,
  input  logic             cfg_pll_off,
  output lp_state_e        state_q,
  output logic [LVL_W-1:0] mask_q,
  output logic             keep_ctrl_q,
  output logic             keep_ext_q,
  output logic             pll_on_q,
  output logic             exit_stop
);

  localparam int RW = (RELOCK_CYC > 1) ? $clog2(RELOCK_CYC) : 1;
  localparam logic [RW-1:0] RELOCK_LOAD = RW'(RELOCK_CYC - 1);

  lp_state_e     state_d;
  logic [RW-1:0] rl_cnt_q;
  logic          pll_off_q;
  logic          wake;

  assign wake = trace_req || irq_wakes(irq_level, mask_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:    if (stop_req) state_d = ST_STOP;
      ST_STOP:   if (wake) state_d = pll_off_q ? ST_RELOCK : ST_RUN;
      ST_RELOCK: if (rl_cnt_q == '0) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  assign exit_stop = (state_q != ST_RUN) && (state_d == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      mask_q      <= '0;
      keep_ctrl_q <= 1'b0;
      keep_ext_q  <= 1'b0;
      pll_off_q   <= 1'b0;
      rl_cnt_q    <= '0;
      pll_on_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && stop_req) begin
        mask_q      <= stop_mask;
        keep_ctrl_q <= cfg_keep_ctrl;
        keep_ext_q  <= cfg_keep_ext;
        pll_off_q   <= cfg_pll_off;
      end
      if (state_q == ST_STOP) begin
        rl_cnt_q <= RELOCK_LOAD;
      end else if (state_q == ST_RELOCK && rl_cnt_q != '0) begin
        rl_cnt_q <= rl_cnt_q - 1'b1;
      end
      if (state_q == ST_RUN && stop_req)
        pll_on_q <= !cfg_pll_off;
      else if (state_d != ST_STOP)
        pll_on_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lpstop_busdiv.sv
`timescale 1ns/1ps
module lpstop_busdiv
  import lpstop_pkg::*;
#(
  parameter int FAST_LOG2 = 3,
  parameter int SLOW_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  lp_state_e  state_q,
  input  logic       exit_stop,
  input  logic       div16,
  input  logic [1:0] pin_mode,
  output logic       bus_clk_q
);

  logic [SLOW_LOG2-1:0] cnt_q;
  logic                 div_q;
  logic                 restart;
  logic                 drive_en;
  logic                 half_bit;

  assign restart  = exit_stop || (div16 != div_q);
  assign drive_en = (state_q == ST_RUN) && (pin_mode == BUS_PIN_ON);
  assign half_bit = div_q ? cnt_q[SLOW_LOG2-1] : cnt_q[FAST_LOG2-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      div_q     <= div16;
      bus_clk_q <= 1'b0;
    end else begin
      div_q     <= div16;
      cnt_q     <= restart ? '0 : cnt_q + 1'b1;
      bus_clk_q <= drive_en && half_bit;
    end
  end

endmodule

// File: rtl/lpstop_gate.sv
`timescale 1ns/1ps
module lpstop_gate
  import lpstop_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  lp_state_e        state_q,
  input  logic             keep_ctrl_q,
  input  logic             keep_ext_q,
  input  logic [N_MOD-1:0] mod_stop,
  output logic             sys_en_q,
  output logic             ctrl_en_q,
  output logic             ext_en_q,
  output logic [N_MOD-1:0] mod_en_q
);

  logic running;
  logic stopped;

  assign running = (state_q == ST_RUN);
  assign stopped = (state_q == ST_STOP);

  // Retimed on the falling edge so gated clocks change only while low.
  always_ff @(negedge clk) begin
    if (rst) begin
      sys_en_q  <= 1'b0;
      ctrl_en_q <= 1'b0;
      ext_en_q  <= 1'b0;
    end else begin
      sys_en_q  <= running;
      ctrl_en_q <= !stopped || keep_ctrl_q;
      ext_en_q  <= running || (stopped && keep_ext_q);
    end
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    always_ff @(negedge clk) begin
      if (rst) mod_en_q[i] <= 1'b0;
      else     mod_en_q[i] <= running && !mod_stop[i];
    end
  end

endmodule

// File: rtl/lpstop_clk_ctrl.sv
`timescale 1ns/1ps
module lpstop_clk_ctrl
  import lpstop_pkg::*;
#(
  parameter int N_MOD      = 4,
  parameter int RELOCK_CYC = 64,
  parameter int FAST_LOG2  = 3,
  parameter int SLOW_LOG2  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic [2:0]       stop_mask,
  input  logic             trace_req,
  input  logic [2:0]       irq_level,
  input  logic             cfg_keep_ctrl,
  input  logic             cfg_keep_ext,
  input  logic             cfg_pll_off,
  input  logic [N_MOD-1:0] mod_stop,
  input  logic             bus_div16,
  input  logic [1:0]       bus_pin_mode,
  output logic             sys_clk_en,
  output logic             ctrl_clk_en,
  output logic             ext_clk_en,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic             pll_on,
  output logic             stop_active,
  output logic             bus_clk
);

  lp_state_e        st_w;
  logic [LVL_W-1:0] mask_w;
  logic             keep_ctrl_w;
  logic             keep_ext_w;
  logic             exit_w;

  lpstop_fsm #(.RELOCK_CYC(RELOCK_CYC)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .stop_req     (stop_req),
    .stop_mask    (stop_mask),
    .trace_req    (trace_req),
    .irq_level    (irq_level),
    .cfg_keep_ctrl(cfg_keep_ctrl),
    .cfg_keep_ext (cfg_keep_ext),
    .cfg_pll_off  (cfg_pll_off),
    .state_q      (st_w),
    .mask_q       (mask_w),
    .keep_ctrl_q  (keep_ctrl_w),
    .keep_ext_q   (keep_ext_w),
    .pll_on_q     (pll_on),
    .exit_stop    (exit_w)
  );

  lpstop_busdiv #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_div (
    .clk      (clk),
    .rst      (rst),
    .state_q  (st_w),
    .exit_stop(exit_w),
    .div16    (bus_div16),
    .pin_mode (bus_pin_mode),
    .bus_clk_q(bus_clk)
  );

  lpstop_gate #(.N_MOD(N_MOD)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .state_q    (st_w),
    .keep_ctrl_q(keep_ctrl_w),
    .keep_ext_q (keep_ext_w),
    .mod_stop   (mod_stop),
    .sys_en_q   (sys_clk_en),
    .ctrl_en_q  (ctrl_clk_en),
    .ext_en_q   (ext_clk_en),
    .mod_en_q   (mod_clk_en)
  );

  assign stop_active = (st_w != ST_RUN);

endmodule

// File: rtl/lpstop_clk_ctrl_chk.sv
`timescale 1ns/1ps
module lpstop_clk_ctrl_chk
  import lpstop_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_req,
  input logic [2:0]       stop_mask,
  input logic             trace_req,
  input logic [2:0]       irq_level,
  input logic             sys_clk_en,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic             pll_on,
  input logic             bus_clk,
  input lp_state_e        st,
  input logic [2:0]       mask_q
);

  p_mask_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && stop_req) |=> (st == ST_STOP && mask_q == $past(stop_mask)));

  p_no_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && !trace_req && irq_level <= mask_q && irq_level != 3'd7)
      |=> st == ST_STOP);

  p_irq_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && irq_level > mask_q) |=> st != ST_STOP);

  p_trace_wake_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && trace_req) |=> st != ST_STOP);

  p_clocks_off_r5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RUN) |-> (!sys_clk_en && mod_clk_en == '0));

  p_relock_pll_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RELOCK) |-> pll_on);

  p_bus_low_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(st) != ST_RUN) |-> !bus_clk);

endmodule

bind lpstop_clk_ctrl lpstop_clk_ctrl_chk #(.N_MOD(N_MOD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_req  (stop_req),
  .stop_mask (stop_mask),
  .trace_req (trace_req),
  .irq_level (irq_level),
  .sys_clk_en(sys_clk_en),
  .mod_clk_en(mod_clk_en),
  .pll_on    (pll_on),
  .bus_clk   (bus_clk),
  .st        (st_w),
  .mask_q    (mask_w)
);

// File: tb/lpstop_clk_ctrl_test.sv
`timescale 1ns/1ps
module lpstop_clk_ctrl_test;

  localparam int NM = 4;
  localparam int RL = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stop_req = 1'b0;
  logic [2:0]    stop_mask = '0;
  logic          trace_req = 1'b0;
  logic [2:0]    irq_level = '0;
  logic          cfg_keep_ctrl = 1'b0;
  logic          cfg_keep_ext = 1'b0;
  logic          cfg_pll_off = 1'b0;
  logic [NM-1:0] mod_stop = '0;
  logic          bus_div16 = 1'b0;
  logic [1:0]    bus_pin_mode = 2'b00;
  logic          sys_clk_en, ctrl_clk_en, ext_clk_en, pll_on, stop_active, bus_clk;
  logic [NM-1:0] mod_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpstop_clk_ctrl #(.N_MOD(NM), .RELOCK_CYC(RL)) uut (
    .clk(clk), .rst(rst), .stop_req(stop_req), .stop_mask(stop_mask),
    .trace_req(trace_req), .irq_level(irq_level),
    .cfg_keep_ctrl(cfg_keep_ctrl), .cfg_keep_ext(cfg_keep_ext),
    .cfg_pll_off(cfg_pll_off), .mod_stop(mod_stop), .bus_div16(bus_div16),
    .bus_pin_mode(bus_pin_mode), .sys_clk_en(sys_clk_en),
    .ctrl_clk_en(ctrl_clk_en), .ext_clk_en(ext_clk_en),
    .mod_clk_en(mod_clk_en), .pll_on(pll_on), .stop_active(stop_active),
    .bus_clk(bus_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lands 1 ns after the next rising edge; inputs driven here are sampled
  // at the following edge, and checks 6 ns later see that edge's results.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic enter_stop(input logic [2:0] m, input logic kc, input logic ke, input logic po);
    stop_req = 1'b1; stop_mask = m;
    cfg_keep_ctrl = kc; cfg_keep_ext = ke; cfg_pll_off = po;
    cyc();
    stop_req = 1'b0; stop_mask = 3'd0;
    cfg_keep_ctrl = 1'b0; cfg_keep_ext = 1'b0; cfg_pll_off = 1'b0;
    #6;
  endtask

  task automatic trace_wake();
    trace_req = 1'b1;
    cyc();
    trace_req = 1'b0;
    #6;
  endtask

  task automatic bus_sweep(input string req, input int period, input int n);
    for (int j = 1; j <= n; j++) begin
      cyc(); #6;
      chk(req, {31'd0, bus_clk}, {31'd0, (((j - 1) % period) >= period / 2)});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc(); #6;
    // R1 reset state
    chk("R1 sys_en", {31'd0, sys_clk_en}, 32'd1);
    chk("R1 ctrl/ext", {30'd0, ctrl_clk_en, ext_clk_en}, 32'd3);
    chk("R1 stop_active", {31'd0, stop_active}, 32'd0);
    chk("R1 pll_on", {31'd0, pll_on}, 32'd1);
    chk("R1 mod_en", {28'd0, mod_clk_en}, 32'hF);

    // R5 module stop bits in run mode
    for (int p = 0; p < (1 << NM); p++) begin
      cyc();
      mod_stop = NM'(p);
      #6;
      chk("R5 mod_en run", {28'd0, mod_clk_en}, {28'd0, ~mod_stop});
    end
    mod_stop = 4'b0101;

    // R3/R4 exhaustive mask x level sweep
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        enter_stop(3'(m), 1'b0, 1'b0, 1'b0);
        chk("R2 entered", {31'd0, stop_active}, 32'd1);
        chk("R5 off in stop", {27'd0, sys_clk_en, mod_clk_en}, 32'd0);
        irq_level = 3'(l);
        cyc();
        irq_level = 3'd0;
        #6;
        chk("R3 wake decision", {31'd0, stop_active},
            {31'd0, !((l > m) || (l == 7))});
        if (stop_active) begin
          trace_wake();
          chk("R4 trace wake", {31'd0, stop_active}, 32'd0);
        end
        chk("R5 back in run", {28'd0, mod_clk_en}, 32'b1010);
      end
    end

    // R2: second strobe in stop ignored, mask stays 5
    enter_stop(3'd5, 1'b0, 1'b0, 1'b0);
    stop_req = 1'b1; stop_mask = 3'd0;
    cyc();
    stop_req = 1'b0;
    irq_level = 3'd3;
    cyc();
    irq_level = 3'd0;
    #6;
    chk("R2 strobe ignored in stop", {31'd0, stop_active}, 32'd1);
    // R4 trace wakes even with a high mask and low request
    irq_level = 3'd1;
    trace_wake();
    irq_level = 3'd0;
    chk("R4 trace with mask 5", {31'd0, stop_active}, 32'd0);

    // R6 keep bits
    for (int k = 0; k < 4; k++) begin
      enter_stop(3'd6, k[1], k[0], 1'b0);
      chk("R6 ctrl/ext in stop", {30'd0, ctrl_clk_en, ext_clk_en}, 32'(k));
      trace_wake();
      chk("R6 ctrl/ext in run", {30'd0, ctrl_clk_en, ext_clk_en}, 32'd3);
    end

    // R7 falling-edge retiming
    cyc();
    stop_req = 1'b1; stop_mask = 3'd2;
    cyc();
    stop_req = 1'b0;
    #2;
    chk("R7 before fall", {31'd0, sys_clk_en}, 32'd1);
    #4;
    chk("R7 after fall", {31'd0, sys_clk_en}, 32'd0);
    trace_wake();

    // R8 PLL off and relock timing
    begin
      int n;
      enter_stop(3'd4, 1'b1, 1'b0, 1'b1);
      chk("R8 pll off in stop", {31'd0, pll_on}, 32'd0);
      irq_level = 3'd7;
      cyc();
      irq_level = 3'd0;
      #6;
      chk("R8 pll on in relock", {31'd0, pll_on}, 32'd1);
      chk("R6 relock ctrl/ext", {30'd0, ctrl_clk_en, ext_clk_en}, 32'd2);
      chk("R8 relock still held", {31'd0, stop_active}, 32'd1);
      n = 0;
      while (!sys_clk_en && n < 50) begin
        cyc(); #6;
        n++;
      end
      chk("R8 relock length", 32'(n), 32'(RL));
    end

    // R10 pin field not selecting the bus clock
    for (int pm = 0; pm < 4; pm++) begin
      if (pm != 2) begin
        bus_pin_mode = 2'(pm);
        begin
          int highs = 0;
          for (int j = 0; j < 20; j++) begin
            cyc(); #6;
            highs += int'(bus_clk);
          end
          chk("R10 pin off held low", 32'(highs), 32'd0);
        end
      end
    end
    bus_pin_mode = 2'b10;

    // R9/R11 divide select change restarts the divider
    cyc();
    bus_div16 = 1'b1;
    cyc(); #6;
    bus_sweep("R9 R11 div16", 16, 40);
    cyc();
    bus_div16 = 1'b0;
    cyc(); #6;
    bus_sweep("R9 R11 div8", 8, 24);

    // R10 low in stop, R11 restart on leaving stop
    enter_stop(3'd7, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 10; j++) begin
      cyc(); #6;
      chk("R10 low in stop", {31'd0, bus_clk}, 32'd0);
    end
    trace_wake();
    chk("R10 low at wake edge", {31'd0, bus_clk}, 32'd0);
    bus_sweep("R11 restart on exit", 8, 20);

    // R1 reset while stopped
    enter_stop(3'd7, 1'b0, 1'b0, 1'b1);
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    cyc(); #6;
    chk("R1 reset wakes", {29'd0, stop_active, sys_clk_en, pll_on}, 32'd3);

    finish_run();
  end

endmodule